// File: doc/BRIEF.md
# Buffered Asynchronous Character Transmitter

This block sends characters over a single asynchronous serial line. The host presents a byte and pulses a write strobe, and the byte lands in a one-entry holding buffer. When transmission is enabled and the output shifter is idle, the byte moves into the shifter. The shifter then drives a framed character onto the line: a low start bit, the data bits with the least significant bit first, an optional parity bit, and one or two high stop bits. If another byte is already waiting when a frame ends, the next frame starts at once.

Two flags describe the pipeline. `bufFree` says the holding buffer can accept a byte. `shiftEmpty` says no frame is on the line. Character length, parity and stop-bit count are static configuration inputs. Every bit lasts 1, 16 or 64 clock cycles, chosen by a rate input.

Top module: `async_char_tx`

## Requirements
- R1: While reset is asserted and right after it, `txLine`, `bufFree` and `shiftEmpty` are all 1.
- R2: A write strobe seen while `bufFree` is 1 stores `wrData` and drives `bufFree` to 0 one cycle later. A write strobe seen while `bufFree` is 0 is dropped, and that byte is never sent.
- R3: While `txEnable` is 0, no byte moves from the buffer to the shifter. `shiftEmpty` stays 1 and `txLine` stays high. The first clock edge that sees `txEnable` at 1 with a full buffer and an idle shifter loads the byte.
- R4: A frame starts with a low start bit and then carries the data bits in order, least significant bit first.
- R5: `charLenSel` sets the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Bits of `wrData` above that length do not appear on the line.
- R6: When `parityOn` is 1, one parity bit follows the last data bit. It is computed over the selected data bits only. It is even parity when `parityOdd` is 0 and odd parity when `parityOdd` is 1.
- R7: The frame ends with one high stop bit when `twoStop` is 0 and two when `twoStop` is 1. An 8-bit character with two stop bits and no parity is therefore 11 bits long.
- R8: Every bit holds for 1 clock cycle when `rateSel` is 0, 16 cycles when it is 1, and 64 cycles when it is 2 or 3.
- R9: On the clock edge that loads the shifter, `shiftEmpty` falls and `bufFree` rises. `shiftEmpty` returns to 1 at the end of the last stop bit, unless another byte is loaded at that same edge.
- R10: If the buffer is full and `txEnable` is 1 when the last stop bit ends, the next start bit begins in the very next cycle, with no idle gap.
- R11: Whenever `shiftEmpty` is 1, `txLine` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Its rate is a multiple of the line rate. |
| rstN | input | 1 | Asynchronous reset, active low. |
| wrStrobe | input | 1 | One-cycle write request from the host. |
| wrData | input | 8 | Character to send. |
| txEnable | input | 1 | Allows bytes to move from the buffer to the shifter. |
| charLenSel | input | 2 | Character length: 0=5, 1=6, 2=7, 3=8 bits. |
| parityOn | input | 1 | Adds a parity bit when 1. |
| parityOdd | input | 1 | Selects odd parity when 1 and even parity when 0. |
| twoStop | input | 1 | Selects two stop bits when 1 and one when 0. |
| rateSel | input | 2 | Clock cycles per bit: 0=1, 1=16, 2 or 3=64. |
| txLine | output | 1 | Serial output. Idles high. |
| bufFree | output | 1 | Holding buffer can accept a byte. |
| shiftEmpty | output | 1 | No frame is being sent. |

## Verification
`bufFree` falls one cycle after an accepted write. When the shifter is idle and enabled, the load follows one cycle after that: `txLine` drops to the start bit while `shiftEmpty` falls and `bufFree` rises. Frame bit j occupies the cycles from j·D to (j+1)·D−1 after the load, where D is the bit length set by `rateSel`. `shiftEmpty` returns high exactly N·D cycles after the load, where N is the frame length. The bench drives inputs and samples outputs on falling edges and walks these cycle counts directly. Every cycle of each bit is compared with the expected level, so a bit that is too long, too short or shifted in time is caught, and not just a wrong value at mid-bit.

// File: rtl/actx_pkg.sv
package actx_pkg;
  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;   // move holding buffer into shifter
    logic shift;  // advance shifter by one bit
  } txStrobes_t;
endpackage

// File: rtl/actx_ctrl.sv
module actx_ctrl
  import actx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int FRAME_W  = 12,
  parameter int DIV_MID  = 16,
  parameter int DIV_HIGH = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txEnable,
  input  logic       bufFull,
  input  logic [1:0] rateSel,
  input  logic [1:0] charLenSel,
  input  logic       parityOn,
  input  logic       twoStop,
  output txStrobes_t strobes,
  output logic       busy
);
  localparam int TICK_W = (DIV_HIGH > 1) ? $clog2(DIV_HIGH) : 1;
  localparam int BIT_W  = $clog2(FRAME_W);

  logic [TICK_W-1:0] tickCnt, divLast;
  logic [BIT_W-1:0]  bitCnt, frameLast;
  logic              bitEnd, frameEnd;

  always_comb begin
    unique case (rateSel)
      2'd0:    divLast = '0;
      2'd1:    divLast = TICK_W'(DIV_MID - 1);
      default: divLast = TICK_W'(DIV_HIGH - 1);
    endcase
    // index of last frame bit: start + data + parity + stops - 1
    frameLast = BIT_W'(DATA_W - 2) + BIT_W'(charLenSel)
              + BIT_W'(parityOn) + BIT_W'(twoStop);
    bitEnd        = busy && (tickCnt == divLast);
    frameEnd      = bitEnd && (bitCnt == frameLast);
    strobes.load  = bufFull && txEnable && (!busy || frameEnd);
    strobes.shift = bitEnd && !frameEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else if (strobes.load) begin
      busy    <= 1'b1;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else if (frameEnd) begin
      busy    <= 1'b0;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else if (bitEnd) begin
      tickCnt <= '0;
      bitCnt  <= bitCnt + 1'b1;
    end else if (busy) begin
      tickCnt <= tickCnt + 1'b1;
    end
  end
endmodule

// File: rtl/actx_datapath.sv
module actx_datapath
  import actx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  txStrobes_t        strobes,
  input  logic              busy,
  input  logic [1:0]        charLenSel,
  input  logic              parityOn,
  input  logic              parityOdd,
  output logic              bufFull,
  output logic              txLine
);
  logic [DATA_W-1:0]  holdReg, masked;
  logic [FRAME_W-1:0] frameReg, frameNext;
  logic               parBit;
  int                 charLen;

  always_comb begin
    charLen = DATA_W - 3 + int'(charLenSel);
    for (int i = 0; i < DATA_W; i++)
      masked[i] = (i < charLen) ? holdReg[i] : 1'b0;
    parBit = (^masked) ^ parityOdd;
    frameNext    = '1;          // stop bits and padding are high
    frameNext[0] = 1'b0;        // start bit
    for (int p = 0; p < DATA_W; p++)
      if (p < charLen) frameNext[p+1] = masked[p];
    for (int p = 0; p <= DATA_W; p++)
      if (parityOn && (p == charLen)) frameNext[p+1] = parBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufFull  <= 1'b0;
      holdReg  <= '0;
      frameReg <= '1;
    end else begin
      if (wrStrobe && !bufFull) begin
        bufFull <= 1'b1;
        holdReg <= wrData;
      end else if (strobes.load) begin
        bufFull <= 1'b0;
      end
      if (strobes.load)
        frameReg <= frameNext;
      else if (strobes.shift)
        frameReg <= {1'b1, frameReg[FRAME_W-1:1]};
    end
  end

  assign txLine = busy ? frameReg[0] : 1'b1;
endmodule

// File: rtl/async_char_tx.sv
module async_char_tx
  import actx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DIV_MID  = 16,
  parameter int DIV_HIGH = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              txEnable,
  input  logic [1:0]        charLenSel,
  input  logic              parityOn,
  input  logic              parityOdd,
  input  logic              twoStop,
  input  logic [1:0]        rateSel,
  output logic              txLine,
  output logic              bufFree,
  output logic              shiftEmpty
);
  localparam int FRAME_W = DATA_W + 4;

  txStrobes_t strobes;
  logic       busy, bufFull;

  actx_ctrl #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .DIV_MID(DIV_MID),
              .DIV_HIGH(DIV_HIGH)) u_ctrl (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .bufFull(bufFull),
    .rateSel(rateSel), .charLenSel(charLenSel), .parityOn(parityOn),
    .twoStop(twoStop), .strobes(strobes), .busy(busy)
  );

  actx_datapath #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .wrData(wrData),
    .strobes(strobes), .busy(busy), .charLenSel(charLenSel),
    .parityOn(parityOn), .parityOdd(parityOdd), .bufFull(bufFull),
    .txLine(txLine)
  );

  assign bufFree    = !bufFull;
  assign shiftEmpty = !busy;
endmodule

// File: rtl/async_char_tx_chk.sv
module async_char_tx_chk (
  input logic clk,
  input logic rstN,
  input logic wrStrobe,
  input logic txEnable,
  input logic txLine,
  input logic bufFree,
  input logic shiftEmpty
);
  assert_idle_high_R11: assert property (@(posedge clk) disable iff (!rstN)
    shiftEmpty |-> txLine);

  assert_write_fills_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && bufFree) |=> !bufFree);

  assert_enable_gate_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!txEnable && shiftEmpty) |=> shiftEmpty);

  assert_start_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(shiftEmpty) |-> !txLine);

  assert_free_on_load_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bufFree) |-> !shiftEmpty);
endmodule

bind async_char_tx async_char_tx_chk u_chk (
  .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .txEnable(txEnable),
  .txLine(txLine), .bufFree(bufFree), .shiftEmpty(shiftEmpty)
);

// File: tb/async_char_tx_tb.sv
module async_char_tx_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0] d;
    logic [1:0] len;
    logic       pOn;
    logic       pOdd;
    logic       two;
    logic [1:0] rate;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{8'h47, 2'd3, 1'b0, 1'b0, 1'b1, 2'd0},  // 11-bit frame (R7)
    '{8'hCA, 2'd2, 1'b0, 1'b0, 1'b1, 2'd0},  // 7 bits, bit7 dropped (R5)
    '{8'hFF, 2'd0, 1'b1, 1'b0, 1'b0, 2'd0},  // 5 bits even parity (R6)
    '{8'h5A, 2'd1, 1'b1, 1'b1, 1'b0, 2'd1},  // 6 bits odd, 16x (R8)
    '{8'h81, 2'd3, 1'b1, 1'b0, 1'b1, 2'd0},
    '{8'h3C, 2'd3, 1'b1, 1'b1, 1'b0, 2'd0},
    '{8'hE0, 2'd0, 1'b1, 1'b1, 1'b1, 2'd1},  // upper bits ignored (R5)
    '{8'h55, 2'd2, 1'b1, 1'b0, 1'b0, 2'd3}   // 64x (R8)
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrStrobe = 1'b0;
  logic [7:0] wrData = '0;
  logic       txEnable = 1'b1;
  logic [1:0] charLenSel = '0;
  logic       parityOn = 1'b0;
  logic       parityOdd = 1'b0;
  logic       twoStop = 1'b0;
  logic [1:0] rateSel = '0;
  logic       txLine, bufFree, shiftEmpty;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  async_char_tx u_dut (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .wrData(wrData),
    .txEnable(txEnable), .charLenSel(charLenSel), .parityOn(parityOn),
    .parityOdd(parityOdd), .twoStop(twoStop), .rateSel(rateSel),
    .txLine(txLine), .bufFree(bufFree), .shiftEmpty(shiftEmpty)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int divOf(vec_t v);
    return (v.rate == 2'd0) ? 1 : (v.rate == 2'd1) ? 16 : 64;
  endfunction

  function automatic int nData(vec_t v);
    return 5 + int'(v.len);
  endfunction

  function automatic int frameLen(vec_t v);
    return 2 + nData(v) + int'(v.pOn) + int'(v.two);
  endfunction

  function automatic logic expBit(vec_t v, int j);
    int n = nData(v);
    logic par = v.pOdd;
    for (int i = 0; i < n; i++) par ^= v.d[i];
    if (j == 0) return 1'b0;
    if (j <= n) return v.d[j-1];
    if (j == n + 1 && v.pOn) return par;
    return 1'b1;
  endfunction

  task automatic applyCfg(vec_t v);
    charLenSel = v.len; parityOn = v.pOn; parityOdd = v.pOdd;
    twoStop = v.two; rateSel = v.rate;
  endtask

  // Called at the falling edge right after the load edge.
  task automatic runBits(vec_t v);
    int dv = divOf(v);
    for (int j = 0; j < frameLen(v); j++) begin
      logic ok = 1'b1;
      string tag = (j == 0) ? "R4" : (j <= nData(v)) ? "R5" :
                   (j == nData(v) + 1 && v.pOn) ? "R6" : "R7";
      for (int k = 0; k < dv; k++) begin
        if (txLine !== expBit(v, j)) ok = 1'b0;
        @(negedge clk);
      end
      chk({tag, "/R8 frame bit level over its full period"}, int'(ok), 1);
    end
    chk("R9 shifter empty after last stop bit", int'(shiftEmpty), 1);
    chk("R11 line high when idle", int'(txLine), 1);
  endtask

  task automatic writeByte(logic [7:0] d);
    wrData = d; wrStrobe = 1'b1;
    @(negedge clk);
    wrStrobe = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 line during reset", int'(txLine), 1);
    chk("R1 bufFree during reset", int'(bufFree), 1);
    chk("R1 shiftEmpty during reset", int'(shiftEmpty), 1);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 line after reset", int'(txLine), 1);
    chk("R1 bufFree after reset", int'(bufFree), 1);
    chk("R1 shiftEmpty after reset", int'(shiftEmpty), 1);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      applyCfg(VECS[i]);
      writeByte(VECS[i].d);
      chk("R2 buffer taken after write", int'(bufFree), 0);
      @(negedge clk);
      chk("R9 shifter busy after load", int'(shiftEmpty), 0);
      chk("R9 buffer free after load", int'(bufFree), 1);
      runBits(VECS[i]);
      repeat (2) @(negedge clk);
    end

    // R3: transmit enable gates the load
    begin
      vec_t v = '{8'h33, 2'd3, 1'b0, 1'b0, 1'b0, 2'd0};
      applyCfg(v);
      txEnable = 1'b0;
      writeByte(v.d);
      repeat (10) @(negedge clk);
      chk("R3 no load while disabled (shiftEmpty)", int'(shiftEmpty), 1);
      chk("R3 no load while disabled (line)", int'(txLine), 1);
      chk("R3 byte still held", int'(bufFree), 0);
      txEnable = 1'b1;
      @(negedge clk);
      chk("R3 load on first enabled edge", int'(shiftEmpty), 0);
      runBits(v);
    end

    // R10 back-to-back, R2 write while full dropped
    begin
      vec_t a = '{8'h0F, 2'd3, 1'b0, 1'b0, 1'b0, 2'd1};
      vec_t b = '{8'hA6, 2'd3, 1'b0, 1'b0, 1'b0, 2'd1};
      repeat (2) @(negedge clk);
      applyCfg(a);
      writeByte(a.d);
      @(negedge clk);                 // A loaded
      chk("R4 start bit of first byte", int'(txLine), 0);
      wrData = b.d; wrStrobe = 1'b1;
      @(negedge clk);                 // B accepted
      wrData = 8'h00;                 // C: buffer full, must be dropped
      @(negedge clk);
      wrStrobe = 1'b0;
      chk("R2 buffer full holding second byte", int'(bufFree), 0);
      repeat (frameLen(a) * divOf(a) - 2) @(negedge clk);
      chk("R10 next start bit with no gap", int'(txLine), 0);
      chk("R10 shifter stays busy", int'(shiftEmpty), 0);
      chk("R9 buffer freed by second load", int'(bufFree), 1);
      runBits(b);
      chk("R2 dropped byte never queued", int'(bufFree), 1);
      repeat (20) @(negedge clk);
      chk("R2 no extra frame after drop", int'(shiftEmpty), 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule